// File: doc/BRIEF.md
# Loop Control Word Execution Unit

This unit carries out a loop-control instruction in a single clock cycle for a machine whose words are 53 bits wide. The control word it receives is packed into four 13-bit fields and one sign bit. On each enabled clock edge the unit does three things at once. It advances the loop counter by the step held in the same word. It checks the advanced counter against the limit field. It then picks the next instruction address: either the jump-address field or the address after the current program counter.

The updated control word comes back out, ready for the surrounding datapath to store. Its low field is also given as a separate index output, so a loop counter can serve as an index register with no extra move. Fetch, decode and storage of the word are left to the surrounding datapath.

Top module: `loop_ctl_unit`

## Requirements
- R1: A synchronous active-high `rst` drives `word_out`, `pc_next`, `taken` and `index_out` to zero on the next rising edge, whatever the other inputs are.
- R2: Field layout of `ctl_word_in` and `word_out`: counter in bits [12:0], step in [25:13], limit in [38:26], jump address in [51:39], sign bit at [52]. The written-back word keeps the step, limit, jump address and sign bit exactly as they came in.
- R3: The new counter is the old counter plus the step, modulo 8192. A carry out of bit 12 is dropped and nothing else signals it.
- R4: `taken` is 1 when the new counter differs from the limit, and 0 when they are equal. The compare always uses the counter after the update.
- R5: When `taken` is 1, `pc_next` equals the jump-address field.
- R6: When `taken` is 0, `pc_next` equals `pc_in` plus one, modulo 8192.
- R7: The update, the compare and the address choice all show on the outputs after the first rising edge at which `exec_en` is high. A loop run by feeding the word back each cycle iterates once per cycle.
- R8: `index_out` equals the new counter, which is also the low field of `word_out`.
- R9: On a rising edge with `exec_en` low and `rst` low, every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Run the loop instruction on this edge |
| ctl_word_in | input | 53 | Packed loop-control word |
| pc_in | input | 13 | Address of the current instruction |
| word_out | output | 53 | Control word with the updated counter |
| pc_next | output | 13 | Next instruction address |
| taken | output | 1 | Branch back to the jump address |
| index_out | output | 13 | Updated counter used as an index |

## Verification
Two events can land on the same edge: the counter wrapping past 8191 and the equality decision. The compare has to see the wrapped value, not the raw sum. The bench provokes this with a counter near the top of its range and a step that carries out. It sets the limit to the wrapped result in one case and to a different value in another, then judges `taken`, `pc_next` and `index_out` against a model that reduces the sum modulo 8192 before comparing. It also makes a fall-through land on address 8191, so the address increment wraps on the same edge that the loop ends.

// File: rtl/lcw_pkg.sv
package lcw_pkg;
   // Width of one field of the machine word
   localparam int LCW_FIELD_W = 13;
   // Number of 13-bit fields in one word
   localparam int LCW_NUM_FIELDS = 4;

   // Slot order inside the word, from least significant upward
   typedef enum logic [1:0] {
      SLOT_CNT  = 2'd0,
      SLOT_STEP = 2'd1,
      SLOT_LIM  = 2'd2,
      SLOT_JMP  = 2'd3
   } lcw_slot_e;

   // Adder variants
   localparam int ADD_PLAIN  = 0;
   localparam int ADD_CSEL   = 1;
   // Comparator variants
   localparam int CMP_FLAT   = 0;
   localparam int CMP_TREE   = 1;
endpackage

// File: rtl/lcw_add.sv
module lcw_add #(
   parameter int W     = 13,
   parameter int STYLE = 0
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   localparam int LO_W = W / 2;
   localparam int HI_W = W - LO_W;

   if (W < 2) begin : g_bad_w
      $error("lcw_add: W must be at least 2");
   end
   if (STYLE != lcw_pkg::ADD_PLAIN && STYLE != lcw_pkg::ADD_CSEL) begin : g_bad_style
      $error("lcw_add: unknown STYLE");
   end

   if (STYLE == lcw_pkg::ADD_CSEL) begin : g_csel
      logic [LO_W:0]   lo_sum;
      logic [HI_W-1:0] hi_c0;
      logic [HI_W-1:0] hi_c1;
      always_comb begin
         lo_sum = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};
         hi_c0  = a[W-1:LO_W] + b[W-1:LO_W];
         hi_c1  = a[W-1:LO_W] + b[W-1:LO_W] + HI_W'(1);
         sum    = {(lo_sum[LO_W] ? hi_c1 : hi_c0), lo_sum[LO_W-1:0]};
      end
   end else begin : g_plain
      always_comb sum = a + b;
   end
endmodule

// File: rtl/lcw_neq.sv
module lcw_neq #(
   parameter int W     = 13,
   parameter int STYLE = 0
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         ne
);
   localparam int GRP    = 4;
   localparam int N_GRP  = (W + GRP - 1) / GRP;
   localparam int PAD_W  = N_GRP * GRP;

   if (STYLE != lcw_pkg::CMP_FLAT && STYLE != lcw_pkg::CMP_TREE) begin : g_bad_style
      $error("lcw_neq: unknown STYLE");
   end

   if (STYLE == lcw_pkg::CMP_TREE) begin : g_tree
      logic [PAD_W-1:0] diff;
      logic [N_GRP-1:0] grp_hit;
      always_comb diff = PAD_W'(a ^ b);
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         always_comb grp_hit[g] = |diff[g*GRP +: GRP];
      end
      always_comb ne = |grp_hit;
   end else begin : g_flat
      always_comb ne = (a != b);
   end
endmodule

// File: rtl/lcw_pcsel.sv
module lcw_pcsel #(
   parameter int AW = 13
)(
   input  logic          go_back,
   input  logic [AW-1:0] jump_addr,
   input  logic [AW-1:0] seq_addr,
   output logic [AW-1:0] next_addr
);
   always_comb next_addr = go_back ? jump_addr : seq_addr;
endmodule

// File: rtl/loop_ctl_unit.sv
module loop_ctl_unit
   import lcw_pkg::*;
#(
   parameter int FIELD_W   = LCW_FIELD_W,
   parameter int ADD_STYLE = ADD_PLAIN,
   parameter int CMP_STYLE = CMP_FLAT,
   localparam int WORD_W   = LCW_NUM_FIELDS * FIELD_W + 1
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               exec_en,
   input  logic [WORD_W-1:0]  ctl_word_in,
   input  logic [FIELD_W-1:0] pc_in,
   output logic [WORD_W-1:0]  word_out,
   output logic [FIELD_W-1:0] pc_next,
   output logic               taken,
   output logic [FIELD_W-1:0] index_out
);
   localparam int I_CNT  = int'(SLOT_CNT);
   localparam int I_STEP = int'(SLOT_STEP);
   localparam int I_LIM  = int'(SLOT_LIM);
   localparam int I_JMP  = int'(SLOT_JMP);

   if (FIELD_W < 2) begin : g_bad_fw
      $error("loop_ctl_unit: FIELD_W must be at least 2");
   end

   // Unpack the word into its fields
   logic [FIELD_W-1:0] fld [LCW_NUM_FIELDS];
   logic               sign_bit;
   for (genvar g = 0; g < LCW_NUM_FIELDS; g++) begin : g_unpack
      always_comb fld[g] = ctl_word_in[g*FIELD_W +: FIELD_W];
   end
   always_comb sign_bit = ctl_word_in[WORD_W-1];

   // Counter step and sequential address
   logic [FIELD_W-1:0] cnt_new;
   logic [FIELD_W-1:0] pc_seq;
   logic               differ;
   logic [FIELD_W-1:0] pc_sel;

   lcw_add #(.W(FIELD_W), .STYLE(ADD_STYLE)) u_cnt_add (
      .a   (fld[I_CNT]),
      .b   (fld[I_STEP]),
      .sum (cnt_new)
   );

   lcw_add #(.W(FIELD_W), .STYLE(ADD_STYLE)) u_pc_inc (
      .a   (pc_in),
      .b   (FIELD_W'(1)),
      .sum (pc_seq)
   );

   lcw_neq #(.W(FIELD_W), .STYLE(CMP_STYLE)) u_lim_cmp (
      .a  (cnt_new),
      .b  (fld[I_LIM]),
      .ne (differ)
   );

   lcw_pcsel #(.AW(FIELD_W)) u_pcsel (
      .go_back   (differ),
      .jump_addr (fld[I_JMP]),
      .seq_addr  (pc_seq),
      .next_addr (pc_sel)
   );

   // Repack: only the counter slot changes
   logic [WORD_W-1:0] wb_word;
   for (genvar g = 0; g < LCW_NUM_FIELDS; g++) begin : g_repack
      if (g == I_CNT) begin : g_cnt
         always_comb wb_word[g*FIELD_W +: FIELD_W] = cnt_new;
      end else begin : g_keep
         always_comb wb_word[g*FIELD_W +: FIELD_W] = fld[g];
      end
   end
   always_comb wb_word[WORD_W-1] = sign_bit;

   always_ff @(posedge clk) begin
      if (rst) begin
         word_out  <= '0;
         pc_next   <= '0;
         taken     <= 1'b0;
         index_out <= '0;
      end else if (exec_en) begin
         word_out  <= wb_word;
         pc_next   <= pc_sel;
         taken     <= differ;
         index_out <= cnt_new;
      end
   end
endmodule

// File: rtl/lcw_checker.sv
module lcw_checker #(
   parameter int FIELD_W = 13,
   localparam int WORD_W = 4 * FIELD_W + 1
)(
   input logic               clk,
   input logic               rst,
   input logic               exec_en,
   input logic [WORD_W-1:0]  ctl_word_in,
   input logic [FIELD_W-1:0] pc_in,
   input logic [WORD_W-1:0]  word_out,
   input logic [FIELD_W-1:0] pc_next,
   input logic               taken,
   input logic [FIELD_W-1:0] index_out
);
   logic edge_seen = 1'b0;
   logic run_seen  = 1'b0;
   always_ff @(posedge clk) begin
      edge_seen <= 1'b1;
      run_seen  <= run_seen | !rst;
   end

   a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      edge_seen && $past(rst) |-> word_out == '0 && pc_next == '0 && !taken && index_out == '0);

   a_r2_upper_kept: assert property (@(posedge clk) disable iff (rst)
      run_seen && $past(exec_en) && !$past(rst)
      |-> word_out[WORD_W-1:FIELD_W] == $past(ctl_word_in[WORD_W-1:FIELD_W]));

   a_r3_counter_wrap: assert property (@(posedge clk) disable iff (rst)
      run_seen && $past(exec_en) && !$past(rst)
      |-> index_out == FIELD_W'($past(ctl_word_in[FIELD_W-1:0]) + $past(ctl_word_in[2*FIELD_W-1:FIELD_W])));

   a_r4_taken_rule: assert property (@(posedge clk) disable iff (rst)
      run_seen && $past(exec_en) && !$past(rst)
      |-> taken == (word_out[FIELD_W-1:0] != $past(ctl_word_in[3*FIELD_W-1:2*FIELD_W])));

   a_r5_jump: assert property (@(posedge clk) disable iff (rst)
      run_seen && $past(exec_en) && !$past(rst) && taken
      |-> pc_next == $past(ctl_word_in[4*FIELD_W-1:3*FIELD_W]));

   a_r6_seq: assert property (@(posedge clk) disable iff (rst)
      run_seen && $past(exec_en) && !$past(rst) && !taken
      |-> pc_next == FIELD_W'($past(pc_in) + FIELD_W'(1)));

   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      run_seen && !$past(exec_en) && !$past(rst)
      |-> $stable(word_out) && $stable(pc_next) && $stable(taken) && $stable(index_out));
endmodule

bind loop_ctl_unit lcw_checker #(.FIELD_W(FIELD_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .exec_en     (exec_en),
   .ctl_word_in (ctl_word_in),
   .pc_in       (pc_in),
   .word_out    (word_out),
   .pc_next     (pc_next),
   .taken       (taken),
   .index_out   (index_out)
);

// File: tb/sim_loop_ctl_unit.sv
module sim_loop_ctl_unit;
   localparam int FW = 13;
   localparam int WW = 4 * FW + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          exec_en = 1'b0;
   logic [WW-1:0] ctl_word_in = '0;
   logic [FW-1:0] pc_in = '0;
   logic [WW-1:0] word_out;
   logic [FW-1:0] pc_next;
   logic          taken;
   logic [FW-1:0] index_out;

   int  checks = 0;
   int  failures = 0;
   logic done = 1'b0;

   // expected state kept by the bench
   logic [WW-1:0] e_word = '0;
   logic [FW-1:0] e_pc = '0;
   logic          e_tk = 1'b0;
   logic [FW-1:0] e_idx = '0;

   always #4 clk = ~clk;

   loop_ctl_unit u0 (
      .clk(clk), .rst(rst), .exec_en(exec_en), .ctl_word_in(ctl_word_in),
      .pc_in(pc_in), .word_out(word_out), .pc_next(pc_next), .taken(taken),
      .index_out(index_out)
   );

   function automatic logic [WW-1:0] mk(input logic s, input logic [FW-1:0] jmp,
      input logic [FW-1:0] lim, input logic [FW-1:0] stp, input logic [FW-1:0] cnt);
      return {s, jmp, lim, stp, cnt};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_outs(input string tag);
      chk({"R2 word ", tag}, 64'(word_out), 64'(e_word));
      chk({"R5/R6 pc ", tag}, 64'(pc_next), 64'(e_pc));
      chk({"R4 taken ", tag}, 64'(taken), 64'(e_tk));
      chk({"R8 index ", tag}, 64'(index_out), 64'(e_idx));
   endtask

   // one enabled edge; expected values from the requirements
   task automatic exec_op(input logic [WW-1:0] w, input logic [FW-1:0] pc, input string tag);
      logic [FW-1:0] cnt, stp, lim, jmp, nc;
      cnt = w[FW-1:0]; stp = w[2*FW-1:FW]; lim = w[3*FW-1:2*FW]; jmp = w[4*FW-1:3*FW];
      nc  = FW'(cnt + stp);
      e_tk   = (nc != lim);
      e_pc   = e_tk ? jmp : FW'(pc + 1);
      e_word = {w[WW-1:FW], nc};
      e_idx  = nc;
      @(negedge clk);
      ctl_word_in = w; pc_in = pc; exec_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exec_en = 1'b0;
      check_outs(tag);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 word after reset", 64'(word_out), 64'd0);
      chk("R1 pc after reset", 64'(pc_next), 64'd0);
      chk("R1 taken after reset", 64'(taken), 64'd0);
      chk("R1 index after reset", 64'(index_out), 64'd0);
      rst = 1'b0;
   endtask

   task automatic t_taken();
      exec_op(mk(1'b0, 13'h100, 13'd10, 13'd1, 13'd5), 13'h020, "R3 basic taken");
      exec_op(mk(1'b1, 13'h0AB, 13'd10, 13'd1, 13'd10), 13'h021, "R4 old count equals limit");
   endtask

   task automatic t_fall_equal();
      // old counter differs from limit, updated one equals it: falls through
      exec_op(mk(1'b0, 13'h100, 13'd10, 13'd1, 13'd9), 13'h020, "R4/R6 updated equals");
      exec_op(mk(1'b1, 13'h1F0, 13'd100, 13'd0, 13'd100), 13'h555, "R6 zero step equal");
   endtask

   task automatic t_wrap();
      // R3 wrap collides with the compare on one edge
      exec_op(mk(1'b1, 13'h0F0, 13'd1, 13'd2, 13'h1FFF), 13'h010, "R3 wrap hits limit");
      exec_op(mk(1'b0, 13'h0F0, 13'h1FFF, 13'd2, 13'h1FFF), 13'h010, "R3 wrap not limit");
      exec_op(mk(1'b0, 13'h0F1, 13'h0, 13'h1FFF, 13'h1), 13'h011, "R3 full step wraps to zero");
   endtask

   task automatic t_pc_wrap();
      exec_op(mk(1'b0, 13'h123, 13'd7, 13'd3, 13'd4), 13'h1FFF, "R6 pc wraps");
   endtask

   task automatic t_hold();
      logic [WW-1:0] hw; logic [FW-1:0] hp; logic ht; logic [FW-1:0] hi;
      exec_op(mk(1'b0, 13'h0AA, 13'd50, 13'd5, 13'd20), 13'h030, "R9 setup");
      hw = e_word; hp = e_pc; ht = e_tk; hi = e_idx;
      @(negedge clk);
      ctl_word_in = mk(1'b1, 13'h1111, 13'd3, 13'd2, 13'd1); pc_in = 13'h0777; exec_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 word held", 64'(word_out), 64'(hw));
      chk("R9 pc held", 64'(pc_next), 64'(hp));
      chk("R9 taken held", 64'(taken), 64'(ht));
      chk("R9 index held", 64'(index_out), 64'(hi));
   endtask

   task automatic t_loop();
      logic [WW-1:0] w; logic [FW-1:0] pc; int n_back;
      w = mk(1'b0, 13'h040, 13'd12, 13'd3, 13'd0); pc = 13'h040; n_back = 0;
      for (int i = 0; i < 4; i++) begin
         exec_op(w, pc, "R7 loop iteration");
         if (e_tk) n_back++;
         w = e_word; pc = e_pc;
      end
      chk("R7 branches back three times", 64'(n_back), 64'd3);
      chk("R7 final counter", 64'(index_out), 64'd12);
   endtask

   task automatic t_patterns();
      logic [63:0] lf; logic [WW-1:0] w; logic [FW-1:0] pc;
      lf = 64'hACE1_2345_6789_BEEF;
      for (int i = 0; i < 24; i++) begin
         lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
         lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
         w  = lf[WW-1:0];
         if (i % 3 == 0) w[3*FW-1:2*FW] = FW'(w[FW-1:0] + w[2*FW-1:FW]);
         pc = lf[63:51];
         exec_op(w, pc, "R3/R4 pattern");
      end
   endtask

   task automatic t_reset_mid();
      exec_op(mk(1'b1, 13'h0BB, 13'd1, 13'd1, 13'd7), 13'h00F, "R1 pre");
      @(negedge clk);
      rst = 1'b1; exec_en = 1'b1;
      ctl_word_in = mk(1'b1, 13'h0CC, 13'd2, 13'd1, 13'd9);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0; exec_en = 1'b0;
      chk("R1 reset beats exec word", 64'(word_out), 64'd0);
      chk("R1 reset beats exec pc", 64'(pc_next), 64'd0);
      chk("R1 reset beats exec taken", 64'(taken), 64'd0);
   endtask

   initial begin
      t_reset();
      t_taken();
      t_fall_equal();
      t_wrap();
      t_pc_wrap();
      t_hold();
      t_loop();
      t_patterns();
      t_reset_mid();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule